// File: doc/BRIEF.md
# Two-Level Sticky Event Interrupt Collector

This block gathers a small set of special link events into one summary status word and drives a single interrupt line from it. Two sources cover the whole link: a multicast event symbol seen on any port, and a port-write-in request seen on any port. Each of up to three serial ports adds its own error source. That error source is fed by five per-port cause flags. Each event input is a one-cycle pulse. It sets a sticky source flag, and a summary bit is raised only on the rising edge of that flag.

Software acknowledges an event in a fixed order. It writes a one to the summary bit in a separate clear register. It then writes ones to the sticky source flags. For a port error, it finally writes a one to the port's level-summary flag. Because a summary bit fires only on a rising source level, it cannot fire again while the lower-level flags are still set. Detection is re-armed only once the full sequence has been completed in the right order. The interrupt line is the OR of the summary bits that have their enable bit set.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the following all read zero: summary word, enable word, mode word, and every port status and control word. The interrupt output is low.
- R2: Word addresses are fixed. Summary is at 0 and is read-only. Clear is at 1 and reads as zero. Enable is at 2. Mode is at 3. Port p status is at 4+2p and port p control is at 5+2p. Writes to the summary word have no effect.
- R3: A multicast pulse sets mode bit 4, and summary bit 0 follows. A port-write-in pulse sets mode bit 0, and summary bit 1 follows. The mode bit is visible the cycle after the pulse and the summary bit one cycle later.
- R4: A port p error pulse sets a port cause flag. The status word holds three of them: fatal at bit 2, failed threshold at bit 25, degraded threshold at bit 24. The control word holds two: illegal transaction at bit 20, max retry at bit 16. Control bit 6 is set one cycle after any cause flag is set. Summary bit 8+p is set one cycle after that.
- R5: Writing 1 to bit n of the clear word clears summary bit n. Writing 0 leaves it unchanged.
- R6: Suppression. While a bit's source flags remain set, further events of that kind do not set the summary bit again after it has been cleared.
- R7: Re-arm for the two link-wide sources. After the summary bit is cleared and its mode bit is cleared by writing 1, a new event sets the summary bit again.
- R8: Re-arm for port errors. All set cause flags must be cleared first, and then control bit 6. While any cause flag is still set, bit 6 cannot be cleared, so clearing out of order leaves the summary bit unable to fire again.
- R9: The enable word resets to zero. Only bits 0, 1 and 8 to 8+NUM_PORTS-1 can be written, and the others read zero. The interrupt output is high exactly when some summary bit and its enable bit are both set.
- R10: A set takes priority over a clear. This holds when a source pulse meets a write-one-to-clear of its flag in the same cycle, and when a summary set meets a clear of that summary bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| ev_mcast | input | 1 | Multicast event symbol pulse, any port |
| ev_pwrite | input | 1 | Port-write-in request pulse, any port |
| ev_fatal | input | NUM_PORTS | Per-port fatal error pulse |
| ev_fail_thr | input | NUM_PORTS | Per-port failed-threshold pulse |
| ev_degr_thr | input | NUM_PORTS | Per-port degraded-threshold pulse |
| ev_illegal | input | NUM_PORTS | Per-port illegal-transaction pulse |
| ev_retry | input | NUM_PORTS | Per-port max-retry pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_PORTS at its maximum of three and ADDR_W of four. This brings every summary bit position and every port address slot into reach.

For every port it sweeps all five cause flags. Each one is taken through first detection, suppression and a complete clear, and then fires again. One port is also driven through the out-of-order clear.

All 32 enable combinations over the five implemented summary bits are swept, with all sources pending and with a single source pending. Exact-cycle probes check the two-stage and three-stage latencies, and both collisions where a set meets a clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned DW         = 32;
   // summary word positions
   localparam int unsigned SUM_MC     = 0;
   localparam int unsigned SUM_PW     = 1;
   localparam int unsigned SUM_PORT0  = 8;
   // mode word source positions
   localparam int unsigned MODE_MC    = 4;
   localparam int unsigned MODE_PW    = 0;
   // port status word cause positions
   localparam int unsigned ST_FATAL   = 2;
   localparam int unsigned ST_FAIL    = 25;
   localparam int unsigned ST_DEGR    = 24;
   // port control word positions
   localparam int unsigned CT_ILL     = 20;
   localparam int unsigned CT_RETRY   = 16;
   localparam int unsigned CT_LVL     = 6;
   // word addresses
   localparam int unsigned A_STAT     = 0;
   localparam int unsigned A_CLR      = 1;
   localparam int unsigned A_EN       = 2;
   localparam int unsigned A_MODE     = 3;
   localparam int unsigned A_PORT     = 4;
   localparam int unsigned NCAUSE     = 5;

   typedef struct packed {
      logic retry;
      logic illegal;
      logic degr_thr;
      logic fail_thr;
      logic fatal;
   } port_cause_t;
endpackage

// File: rtl/evt_sticky_bits.sv
module evt_sticky_bits #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("evt_sticky_bits: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))) else $error("set lost"); // R10
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0)) else $error("clear lost"); // R5
endmodule

// File: rtl/evt_port_err.sv
module evt_port_err
   import evt_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  port_cause_t       ev_i,
   input  logic [NCAUSE-1:0] clr_cause_i,
   input  logic              clr_lvl_i,
   output port_cause_t       cause_o,
   output logic              lvl_o
);
   logic [NCAUSE-1:0] cause_q;
   logic [0:0]        lvl_q;
   logic              any_cause;

   evt_sticky_bits #(.W(NCAUSE)) u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_i),
      .clr_i (clr_cause_i),
      .q_o   (cause_q)
   );

   assign any_cause = |cause_q;

   evt_sticky_bits #(.W(1)) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (any_cause),
      .clr_i (clr_lvl_i),
      .q_o   (lvl_q)
   );

   assign cause_o = port_cause_t'(cause_q);
   assign lvl_o   = lvl_q[0];

   AST_LVL_TRACKS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_o != '0) |=> lvl_o) else $error("level flag missed a cause"); // R4
   AST_LVL_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl_o) |-> ($past(cause_o) == '0)) else $error("level flag dropped with cause set"); // R8
endmodule

// File: rtl/evt_summary.sv
module evt_summary #(
   parameter int unsigned   W    = 11,
   parameter logic [W-1:0]  MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] clr_i,
   input  logic         en_wr_i,
   input  logic [W-1:0] en_data_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] en_o,
   output logic         irq_o
);
   logic [W-1:0] lvl_d;
   logic [W-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d <= '0;
         en_o  <= '0;
      end else begin
         lvl_d <= lvl_i & MASK;
         if (en_wr_i) en_o <= en_data_i & MASK;
      end
   end

   assign rise = lvl_i & ~lvl_d & MASK;

   evt_sticky_bits #(.W(W)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (rise),
      .clr_i (clr_i & MASK),
      .q_o   (sum_o)
   );

   assign irq_o = |(sum_o & en_o);

   AST_SUM_NEEDS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      ((sum_o & ~$past(sum_o) & ~$past(lvl_i)) == '0)) else $error("summary set without source"); // R6
   AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
      ((sum_o & ~$past(sum_o) & $past(lvl_i, 2)) == '0)) else $error("summary refired on held level"); // R6
   AST_IRQ_NEEDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (sum_o != '0)) else $error("irq with empty summary"); // R9
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   input  logic                 ev_mcast,
   input  logic                 ev_pwrite,
   input  logic [NUM_PORTS-1:0] ev_fatal,
   input  logic [NUM_PORTS-1:0] ev_fail_thr,
   input  logic [NUM_PORTS-1:0] ev_degr_thr,
   input  logic [NUM_PORTS-1:0] ev_illegal,
   input  logic [NUM_PORTS-1:0] ev_retry,
   output logic                 irq
);
   localparam int unsigned SW        = SUM_PORT0 + NUM_PORTS;
   localparam int unsigned LAST_ADDR = A_PORT + 2 * NUM_PORTS - 1;
   localparam logic [SW-1:0] IMPL_MASK =
      SW'(((32'd1 << NUM_PORTS) - 32'd1) << SUM_PORT0) | SW'(32'd3);

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > 3) begin : g_bad_np
         $error("evt_irq_ctrl: NUM_PORTS must be 1 to 3");
      end
      if (LAST_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_aw
         $error("evt_irq_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic wr_clr, wr_en, wr_mode;
   logic [1:0]           mode_q;   // [0] multicast, [1] port-write-in
   logic [SW-1:0]        lvl;
   logic [SW-1:0]        sum;
   logic [SW-1:0]        en;
   logic [NUM_PORTS-1:0] port_lvl;
   port_cause_t          cause [NUM_PORTS];
   logic                 unused_wdata;

   assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(A_CLR));
   assign wr_en   = bus_wr && (bus_addr == ADDR_W'(A_EN));
   assign wr_mode = bus_wr && (bus_addr == ADDR_W'(A_MODE));
   assign unused_wdata = ^bus_wdata;

   evt_sticky_bits #(.W(2)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i ({ev_pwrite, ev_mcast}),
      .clr_i ({wr_mode & bus_wdata[MODE_PW], wr_mode & bus_wdata[MODE_MC]}),
      .q_o   (mode_q)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         logic              wr_st, wr_ct;
         port_cause_t       ev;
         logic [NCAUSE-1:0] clr_c;
         assign wr_st = bus_wr && (bus_addr == ADDR_W'(A_PORT + 2 * p));
         assign wr_ct = bus_wr && (bus_addr == ADDR_W'(A_PORT + 2 * p + 1));
         assign ev.fatal    = ev_fatal[p];
         assign ev.fail_thr = ev_fail_thr[p];
         assign ev.degr_thr = ev_degr_thr[p];
         assign ev.illegal  = ev_illegal[p];
         assign ev.retry    = ev_retry[p];
         assign clr_c = {wr_ct & bus_wdata[CT_RETRY], wr_ct & bus_wdata[CT_ILL],
                         wr_st & bus_wdata[ST_DEGR],  wr_st & bus_wdata[ST_FAIL],
                         wr_st & bus_wdata[ST_FATAL]};

         evt_port_err u_err (
            .clk         (clk),
            .rst_n       (rst_n),
            .ev_i        (ev),
            .clr_cause_i (clr_c),
            .clr_lvl_i   (wr_ct & bus_wdata[CT_LVL]),
            .cause_o     (cause[p]),
            .lvl_o       (port_lvl[p])
         );
      end
   endgenerate

   always_comb begin
      lvl = '0;
      lvl[SUM_MC] = mode_q[0];
      lvl[SUM_PW] = mode_q[1];
      for (int p = 0; p < NUM_PORTS; p++) lvl[SUM_PORT0 + p] = port_lvl[p];
   end

   evt_summary #(.W(SW), .MASK(IMPL_MASK)) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (lvl),
      .clr_i     (wr_clr ? bus_wdata[SW-1:0] : '0),
      .en_wr_i   (wr_en),
      .en_data_i (bus_wdata[SW-1:0]),
      .sum_o     (sum),
      .en_o      (en),
      .irq_o     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_STAT)) bus_rdata = DW'(sum);
      if (bus_addr == ADDR_W'(A_EN))   bus_rdata = DW'(en);
      if (bus_addr == ADDR_W'(A_MODE)) begin
         bus_rdata[MODE_MC] = mode_q[0];
         bus_rdata[MODE_PW] = mode_q[1];
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (bus_addr == ADDR_W'(A_PORT + 2 * p)) begin
            bus_rdata[ST_FATAL] = cause[p].fatal;
            bus_rdata[ST_FAIL]  = cause[p].fail_thr;
            bus_rdata[ST_DEGR]  = cause[p].degr_thr;
         end
         if (bus_addr == ADDR_W'(A_PORT + 2 * p + 1)) begin
            bus_rdata[CT_ILL]   = cause[p].illegal;
            bus_rdata[CT_RETRY] = cause[p].retry;
            bus_rdata[CT_LVL]   = port_lvl[p];
         end
      end
   end

   AST_MODE_FEEDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_q[0]) |=> sum[SUM_MC]) else $error("multicast summary missed"); // R3
   AST_EN_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((en & ~IMPL_MASK) == '0)) else $error("unimplemented enable bit set"); // R9
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
   localparam int NP = 3;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          ev_mcast = 1'b0, ev_pwrite = 1'b0;
   logic [NP-1:0] ev_fatal = '0, ev_fail_thr = '0, ev_degr_thr = '0, ev_illegal = '0, ev_retry = '0;
   logic          irq;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   evt_irq_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_mcast(ev_mcast),
      .ev_pwrite(ev_pwrite), .ev_fatal(ev_fatal), .ev_fail_thr(ev_fail_thr),
      .ev_degr_thr(ev_degr_thr), .ev_illegal(ev_illegal), .ev_retry(ev_retry),
      .irq(irq)
   );

   function automatic int cpos(int c);
      case (c)
         0: return 2;  1: return 25; 2: return 24; 3: return 20; default: return 16;
      endcase
   endfunction
   function automatic int stat_a(int p); return 4 + 2 * p; endfunction
   function automatic int ctl_a(int p);  return 5 + 2 * p; endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   task automatic rchk(string tag, int a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic pulse_src(int kind);
      if (kind == 0) ev_mcast = 1'b1; else ev_pwrite = 1'b1;
      @(negedge clk);
      ev_mcast = 1'b0; ev_pwrite = 1'b0;
   endtask

   task automatic pulse_port(int p, int c);
      case (c)
         0: ev_fatal[p] = 1'b1;
         1: ev_fail_thr[p] = 1'b1;
         2: ev_degr_thr[p] = 1'b1;
         3: ev_illegal[p] = 1'b1;
         default: ev_retry[p] = 1'b1;
      endcase
      @(negedge clk);
      ev_fatal = '0; ev_fail_thr = '0; ev_degr_thr = '0; ev_illegal = '0; ev_retry = '0;
   endtask

   task automatic clear_port(int p);
      wr(stat_a(p), 32'h0300_0004);
      wr(ctl_a(p), 32'h0011_0000);
      wr(ctl_a(p), 32'h0000_0040);
   endtask

   task automatic clean_all();
      wr(1, 32'hFFFF_FFFF);
      wr(3, 32'h0000_0011);
      for (int p = 0; p < NP; p++) clear_port(p);
      tick(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      tick(3);
      // R1 reset values
      check("R1 irq", {31'd0, irq}, 32'd0);
      rchk("R1 summary", 0, 0);
      rchk("R1 enable", 2, 0);
      rchk("R1 mode", 3, 0);
      for (int p = 0; p < NP; p++) begin
         rchk("R1 port status", stat_a(p), 0);
         rchk("R1 port control", ctl_a(p), 0);
      end
      rst_n = 1'b1;
      tick(2);
      rchk("R1 summary after release", 0, 0);

      // R3 exact latency, multicast
      ev_mcast = 1'b1;
      @(negedge clk); ev_mcast = 1'b0;
      rchk("R3 mode bit 4 after one cycle", 3, 32'h10);
      rchk("R3 summary not yet", 0, 0);
      tick(1);
      rchk("R3 summary bit 0", 0, 32'h1);
      // R2 clear reads zero, summary ignores writes
      rchk("R2 clear reads zero", 1, 0);
      wr(0, 32'h0);
      rchk("R2 summary write ignored", 0, 32'h1);
      // R5 writing zeros has no effect
      wr(1, 32'h0);
      rchk("R5 zero clear no effect", 0, 32'h1);
      // R6 suppression
      wr(1, 32'h1);
      rchk("R5 clear bit 0", 0, 0);
      pulse_src(0); tick(3);
      rchk("R6 multicast suppressed", 0, 0);
      // R7 re-arm
      wr(3, 32'h10);
      rchk("R7 mode cleared", 3, 0);
      pulse_src(0); tick(3);
      rchk("R7 multicast refires", 0, 32'h1);

      // port-write-in source
      pulse_src(1);
      rchk("R3 mode bit 0", 3, 32'h11);
      tick(2);
      rchk("R3 summary bit 1", 0, 32'h3);
      wr(1, 32'h2);
      pulse_src(1); tick(3);
      rchk("R6 port-write suppressed", 0, 32'h1);
      wr(3, 32'h01);
      rchk("R7 mode bit 0 cleared only", 3, 32'h10);
      pulse_src(1); tick(3);
      rchk("R7 port-write refires", 0, 32'h3);
      clean_all();
      rchk("R5 all cleared", 0, 0);

      // R4 exact latency, port error
      ev_fatal[1] = 1'b1;
      @(negedge clk); ev_fatal = '0;
      rchk("R4 cause after one cycle", stat_a(1), 32'h4);
      rchk("R4 level flag not yet", ctl_a(1), 0);
      tick(1);
      rchk("R4 level flag after two", ctl_a(1), 32'h40);
      rchk("R4 summary not yet", 0, 0);
      tick(1);
      rchk("R4 summary after three", 0, 32'h200);
      clean_all();

      // R4 R6 R8 sweep over ports and causes
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 5; c++) begin
            logic [31:0] cb;
            cb = 32'd1 << cpos(c);
            pulse_port(p, c); tick(3);
            rchk("R4 status word", stat_a(p), (c < 3) ? cb : 32'h0);
            rchk("R4 control word", ctl_a(p), ((c >= 3) ? cb : 32'h0) | 32'h40);
            rchk("R4 summary port bit", 0, 32'd1 << (8 + p));
            wr(1, 32'd1 << (8 + p));
            pulse_port(p, c); tick(3);
            rchk("R6 port error suppressed", 0, 0);
            clear_port(p); tick(1);
            rchk("R8 control clean", ctl_a(p), 0);
            rchk("R8 status clean", stat_a(p), 0);
            pulse_port(p, c); tick(3);
            rchk("R8 port error refires", 0, 32'd1 << (8 + p));
            clean_all();
         end
      end

      // R8 out-of-order clear on port 2
      pulse_port(2, 4); tick(3);
      wr(1, 32'h400);
      wr(ctl_a(2), 32'h40);
      rchk("R8 level held by cause", ctl_a(2), 32'h0001_0040);
      wr(ctl_a(2), 32'h0001_0000);
      rchk("R8 level still set", ctl_a(2), 32'h40);
      pulse_port(2, 4); tick(3);
      rchk("R8 out-of-order no refire", 0, 0);
      wr(ctl_a(2), 32'h0001_0000);
      wr(ctl_a(2), 32'h40);
      rchk("R8 level cleared in order", ctl_a(2), 0);
      pulse_port(2, 0); tick(3);
      rchk("R8 refire after proper order", 0, 32'h400);
      clean_all();

      // R10 source set beats W1C
      bus_wr = 1'b1; bus_addr = AW'(stat_a(0)); bus_wdata = 32'h4; ev_fatal[0] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; ev_fatal = '0;
      rchk("R10 cause set wins", stat_a(0), 32'h4);
      tick(2);
      clean_all();
      // R10 summary set beats clear
      ev_mcast = 1'b1;
      @(negedge clk); ev_mcast = 1'b0;
      wr(1, 32'h1);
      rchk("R10 summary set wins", 0, 32'h1);
      clean_all();

      // R9 enable mask and interrupt sweep
      wr(2, 32'hFFFF_FFFF);
      rchk("R9 enable implemented bits", 2, 32'h0000_0703);
      tick(1);
      check("R9 irq none pending", {31'd0, irq}, 32'd0);
      pulse_src(0); pulse_src(1);
      for (int p = 0; p < NP; p++) pulse_port(p, 0);
      tick(3);
      rchk("R9 all pending", 0, 32'h703);
      for (int m = 0; m < 32; m++) begin
         logic [31:0] e;
         e = (m & 3) | ((m >> 2) << 8);
         wr(2, e);
         #1 check("R9 irq all pending", {31'd0, irq}, {31'd0, m != 0});
      end
      wr(1, 32'h503);
      rchk("R9 only port 1 pending", 0, 32'h200);
      for (int m = 0; m < 32; m++) begin
         logic [31:0] e;
         e = (m & 3) | ((m >> 2) << 8);
         wr(2, e);
         #1 check("R9 irq one pending", {31'd0, irq}, {31'd0, ((m >> 3) & 1) == 1});
      end
      rd(2, v);
      check("R9 enable readback", v, 32'h0703);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule